// File: doc/BRIEF.md
# Two-Level Grouped Carry-Lookahead Adder

This block adds two 32-bit operands and a carry-in with no clock, giving a 32-bit sum and a separate carry-out. Each operand bit first yields a bit generate (a AND b) and a bit propagate (a XOR b). The word is cut into eight 4-bit groups. Each group forms its own sum bits from its incoming carry, and it also reports a group generate and a group propagate to the level above.

The upper level has two lookahead sections, and each one serves four groups, or 16 bits. A section takes the four group generate/propagate pairs and its entry carry and works out the carry into each of its groups plus the carry out of the section. The carry-in of the adder enters the low section. The carry out of the low section becomes the entry carry of the high section. The carry out of the high section is the carry-out of the adder. The block is used wherever a flat combinational add is wanted whose critical path crosses only two group levels per 16-bit half.

Top module: `gla_add32`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin` as a 33-bit unsigned integer for every input.
- R2: Bit i of the sum equals `a[i] ^ b[i] ^ c[i]`, where c[i] is the carry into bit i. Bit 0 takes `cin` as its carry.
- R3: With `cin = 1` and both operands all ones, the sum is all ones and `cout = 1`. With `cin = 1`, `a` all ones and `b = 0`, the carry travels through all 32 bits: the sum is 0 and `cout = 1`.
- R4: Zero operands with `cin = 0` give a zero sum and `cout = 0`. With `cin = 1` they give `sum = 1` and `cout = 0`.
- R5: The carry into bit 16 depends only on bits 15:0 and `cin`. When the low half overflows, bit 16 receives a carry and nothing else in the low half changes the high half.
- R6: No output bit is ever X or Z while all inputs are 0 or 1.
- R7: The carry into each 4-bit group k (k = 1..7) is 1 exactly when `a[4k-1:0] + b[4k-1:0] + cin` reaches 2^(4k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The case that is hardest to reach from the ports is a carry that starts at bit 0 and has to cross every group and the joint between the two sections. Random operands almost never make all 32 bits propagate. The stimulus sets `cin` to 1 and `a` to all ones, then sweeps `b` across one-hot values, so that the propagate chain is broken at every bit position in turn. Exhaustive sweeps over every 4-bit group pattern, each repeated into all eight groups, also drive every group generate/propagate combination through both lookahead sections at once.

// File: rtl/gla_add32.sv
module gla_add32 (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        cin,
  output logic [31:0] sum,
  output logic        cout
);

  logic [31:0] g, p, c;
  logic [7:0]  gg, gp;
  logic [8:0]  gc;

  assign g = a & b;
  assign p = a ^ b;

  for (genvar k = 0; k < 8; k++) begin : grp
    logic [3:0] gi, pi;
    assign gi = g[4*k +: 4];
    assign pi = p[4*k +: 4];
    assign gg[k] = gi[3] | (pi[3] & gi[2]) | (pi[3] & pi[2] & gi[1])
                 | (pi[3] & pi[2] & pi[1] & gi[0]);
    assign gp[k] = &pi;
    assign c[4*k]   = gc[k];
    assign c[4*k+1] = gi[0] | (pi[0] & gc[k]);
    assign c[4*k+2] = gi[1] | (pi[1] & gi[0]) | (pi[1] & pi[0] & gc[k]);
    assign c[4*k+3] = gi[2] | (pi[2] & gi[1]) | (pi[2] & pi[1] & gi[0])
                    | (pi[2] & pi[1] & pi[0] & gc[k]);
    assign sum[4*k +: 4] = pi ^ c[4*k +: 4];
  end

  assign gc[0] = cin;
  for (genvar s = 0; s < 2; s++) begin : sec
    logic [3:0] sg, sp;
    logic       ci;
    assign sg = gg[4*s +: 4];
    assign sp = gp[4*s +: 4];
    assign ci = gc[4*s];
    assign gc[4*s+1] = sg[0] | (sp[0] & ci);
    assign gc[4*s+2] = sg[1] | (sp[1] & sg[0]) | (sp[1] & sp[0] & ci);
    assign gc[4*s+3] = sg[2] | (sp[2] & sg[1]) | (sp[2] & sp[1] & sg[0])
                     | (sp[2] & sp[1] & sp[0] & ci);
    assign gc[4*s+4] = sg[3] | (sp[3] & sg[2]) | (sp[3] & sp[2] & sg[1])
                     | (sp[3] & sp[2] & sp[1] & sg[0])
                     | (sp[3] & sp[2] & sp[1] & sp[0] & ci);
  end

  assign cout = gc[8];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r1_sum_matches: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + {32'd0, cin});
      a_r6_no_unknown: assert (!$isunknown({cout, sum}));
      a_r5_mid_carry: assert (gc[4] == ((({1'b0, a[15:0]} + {1'b0, b[15:0]}) + {16'd0, cin}) >> 16));
      a_r2_bit0: assert (sum[0] == (a[0] ^ b[0] ^ cin));
    end
  end

endmodule

// File: tb/gla_add32_test.sv
module gla_add32_test;
  logic clk = 0;
  logic [31:0] a = 0, b = 0;
  logic cin = 0;
  logic [31:0] sum;
  logic cout;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gla_add32 uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic check(input string req, input logic [31:0] x, input logic [31:0] y, input logic ci);
    logic [32:0] exp;
    a = x; b = y; cin = ci;
    @(negedge clk);
    exp = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    checks++;
    if ($isunknown({cout, sum}) || {cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b got %h expected %h", req, x, y, ci, {cout, sum}, exp);
    end
  endtask

  initial begin
    fork
      begin
        // R4: zeros
        check("R4", 32'h0, 32'h0, 1'b0);
        check("R4", 32'h0, 32'h0, 1'b1);
        // R3: full propagation
        check("R3", 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        check("R3", 32'hFFFFFFFF, 32'h0, 1'b1);
        check("R3", 32'h0, 32'hFFFFFFFF, 1'b1);
        // R2 alternating patterns
        check("R2", 32'hAAAAAAAA, 32'h55555555, 1'b0);
        check("R2", 32'hAAAAAAAA, 32'h55555555, 1'b1);
        check("R2", 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b1);
        check("R2", 32'h55555555, 32'h55555555, 1'b0);
        // R5: low half overflow into high half
        check("R5", 32'h0000FFFF, 32'h00000001, 1'b0);
        check("R5", 32'h1234FFFF, 32'h00000000, 1'b1);
        check("R5", 32'h0000FFFF, 32'h0000FFFF, 1'b1);
        // R7: chain broken at each bit
        for (int i = 0; i < 32; i++) begin
          check("R7", 32'hFFFFFFFF, 32'h1 << i, 1'b1);
          check("R7", 32'hFFFFFFFF ^ (32'h1 << i), 32'h0, 1'b1);
        end
        // R1/R6: exhaustive group patterns replicated across all groups
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            for (int ci = 0; ci < 2; ci++)
              check("R1", {8{x[3:0]}}, {8{y[3:0]}}, ci[0]);
        // R6: random vectors
        for (int n = 0; n < 2000; n++)
          check("R6", $urandom, $urandom, 1'($urandom));
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule